// File: doc/BRIEF.md
# Pending-Destination Hazard Scoreboard

This block records the destination registers of instructions that have left the decode stage but have not yet written their results back. A decode stage asks it, on two independent query ports, whether either source operand of the instruction in hand matches a pending destination. If either port reports a hit, decode holds the instruction. Only an instruction that actually issues adds its destination, which may be absent, to the record.

Entries live in a small circular buffer in issue order. Each time a later stage consumes an instruction, the oldest entry retires, whether or not that instruction was discarded. Within one cycle, retirement acts before issue. A full scoreboard can therefore take a new entry in the same cycle that one retires. Queries see the entries held at the start of the cycle, minus any entry that retires in that same cycle. An entry added in a cycle becomes visible on the following one.

Top module: `reg_hazard_board`

## Requirements
- R1: While reset is asserted and right after it, `empty` is 1, `full` is 0, and neither hit output is asserted.
- R2: After an issue with a present destination index, a query on either port with that same present index reports a hit, and a query with a different index does not.
- R3: An entry added in a cycle is not seen by queries in that cycle; it is seen from the next cycle on.
- R4: A query whose source is marked absent never hits. An entry whose destination is marked absent still takes a slot and counts toward `full`, but it never matches any query.
- R5: A retire removes the oldest entry (first in, first out), not the newest.
- R6: Queries ignore the entry that retires in the current cycle.
- R7: `full` is 1 when DEPTH entries are held. With `full` at 1, an issue and a retire in the same cycle are both accepted, `full` stays 1, and the new entry can be queried next cycle.
- R8: `empty` is 1 exactly when no entries are held. Issuing while full without a retire, and retiring while empty, are illegal and are flagged.
- R9: The two query ports work independently; in one cycle one port can hit while the other misses.
- R10: Two pending entries with the same index are tracked separately; after one of them retires, the index still hits until the second one retires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_en | input | 1 | Issue: add an entry this cycle |
| ins_vld | input | 1 | Issued destination is present |
| ins_idx | input | IDX_W | Issued destination register index |
| rm_en | input | 1 | Retire the oldest entry this cycle |
| src_a_vld | input | 1 | Query port A source is present |
| src_a_idx | input | IDX_W | Query port A register index |
| hit_a | output | 1 | Port A matches a pending destination |
| src_b_vld | input | 1 | Query port B source is present |
| src_b_idx | input | IDX_W | Query port B register index |
| hit_b | output | 1 | Port B matches a pending destination |
| full | output | 1 | DEPTH entries held |
| empty | output | 1 | No entries held |

## Verification
The bench runs the buffer to full and then issues and retires in the same cycle. A design that let issue act before retire would refuse that entry, and the slot counts would drift apart from the instructions in flight. It queries an index in the same cycle as the retire of the entry holding it. A design that still showed that entry would stall decode for a cycle that needs no stall. It also queries in the cycle of an issue, which catches a same-cycle bypass that should not exist. Entries with absent destinations, absent sources and duplicated indices show whether the slot order stays tied to instructions and whether a retire removes the oldest entry rather than an arbitrary match.

// File: rtl/hzb_pkg.sv
package hzb_pkg;
  localparam int HZB_IDX_W_DEF = 5;
  localparam int HZB_DEPTH_DEF = 2;

  // Distance from the oldest slot to a given slot, walking the ring.
  function automatic int ring_age(input int slot, input int head, input int depth);
    if (slot >= head) return slot - head;
    return slot + depth - head;
  endfunction
endpackage

// File: rtl/hzb_ptr_ctrl.sv
module hzb_ptr_ctrl #(
  parameter int DEPTH = 2,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_go,
  input  logic             rm_go,
  output logic [PTR_W-1:0] head,
  output logic [PTR_W-1:0] tail,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CAP  = CNT_W'(DEPTH);

  logic [PTR_W-1:0] head_nx, tail_nx;
  logic [CNT_W-1:0] count_nx;

  always_comb begin
    head_nx  = head;
    tail_nx  = tail;
    count_nx = count;
    if (rm_go)  head_nx = (head == LAST) ? '0 : head + 1'b1;
    if (ins_go) tail_nx = (tail == LAST) ? '0 : tail + 1'b1;
    if (ins_go && !rm_go) count_nx = count + 1'b1;
    else if (rm_go && !ins_go) count_nx = count - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      head  <= head_nx;
      tail  <= tail_nx;
      count <= count_nx;
    end
  end

  assign full  = (count == CAP);
  assign empty = (count == '0);
endmodule

// File: rtl/hzb_store.sv
module hzb_store #(
  parameter int IDX_W = 5,
  parameter int DEPTH = 2,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                       clk,
  input  logic                       ins_go,
  input  logic [PTR_W-1:0]           tail,
  input  logic                       ins_vld,
  input  logic [IDX_W-1:0]           ins_idx,
  output logic [DEPTH-1:0]           slot_vld,
  output logic [DEPTH-1:0][IDX_W-1:0] slot_idx
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic wr_en;
    assign wr_en = ins_go && (tail == PTR_W'(i));
    always_ff @(posedge clk) begin
      if (wr_en) begin
        slot_vld[i] <= ins_vld;
        slot_idx[i] <= ins_idx;
      end
    end
  end
endmodule

// File: rtl/hzb_match.sv
module hzb_match #(
  parameter int IDX_W = 5,
  parameter int DEPTH = 2,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH-1:0]            slot_vld,
  input  logic [DEPTH-1:0][IDX_W-1:0] slot_idx,
  input  logic [PTR_W-1:0]            head,
  input  logic [CNT_W-1:0]            count,
  input  logic                        rm_go,
  input  logic                        q_vld,
  input  logic [IDX_W-1:0]            q_idx,
  output logic                        hit
);
  logic [DEPTH-1:0] slot_hit;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    int   age;
    logic live;
    assign age  = hzb_pkg::ring_age(i, int'(head), DEPTH);
    assign live = (age < int'(count)) && !(rm_go && (age == 0));
    assign slot_hit[i] = live && slot_vld[i] && q_vld && (slot_idx[i] == q_idx);
  end

  assign hit = |slot_hit;
endmodule

// File: rtl/reg_hazard_board.sv
module reg_hazard_board #(
  parameter int IDX_W = hzb_pkg::HZB_IDX_W_DEF,
  parameter int DEPTH = hzb_pkg::HZB_DEPTH_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_en,
  input  logic             ins_vld,
  input  logic [IDX_W-1:0] ins_idx,
  input  logic             rm_en,
  input  logic             src_a_vld,
  input  logic [IDX_W-1:0] src_a_idx,
  output logic             hit_a,
  input  logic             src_b_vld,
  input  logic [IDX_W-1:0] src_b_idx,
  output logic             hit_b,
  output logic             full,
  output logic             empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [PTR_W-1:0]            head, tail;
  logic [CNT_W-1:0]            count;
  logic [DEPTH-1:0]            slot_vld;
  logic [DEPTH-1:0][IDX_W-1:0] slot_idx;
  logic                        ins_go, rm_go;

  // Retire first: a full buffer takes an issue when a retire frees a slot.
  assign rm_go  = rm_en && !empty;
  assign ins_go = ins_en && (!full || rm_go);

  hzb_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst_n(rst_n), .ins_go(ins_go), .rm_go(rm_go),
    .head(head), .tail(tail), .count(count), .full(full), .empty(empty)
  );

  hzb_store #(.IDX_W(IDX_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .ins_go(ins_go), .tail(tail), .ins_vld(ins_vld), .ins_idx(ins_idx),
    .slot_vld(slot_vld), .slot_idx(slot_idx)
  );

  hzb_match #(.IDX_W(IDX_W), .DEPTH(DEPTH)) u_match_a (
    .slot_vld(slot_vld), .slot_idx(slot_idx), .head(head), .count(count),
    .rm_go(rm_go), .q_vld(src_a_vld), .q_idx(src_a_idx), .hit(hit_a)
  );

  hzb_match #(.IDX_W(IDX_W), .DEPTH(DEPTH)) u_match_b (
    .slot_vld(slot_vld), .slot_idx(slot_idx), .head(head), .count(count),
    .rm_go(rm_go), .q_vld(src_b_vld), .q_idx(src_b_idx), .hit(hit_b)
  );
endmodule

// File: rtl/hzb_checker.sv
module hzb_checker (
  input logic clk,
  input logic rst_n,
  input logic ins_en,
  input logic rm_en,
  input logic src_a_vld,
  input logic src_b_vld,
  input logic hit_a,
  input logic hit_b,
  input logic full,
  input logic empty
);
  // R8: issue into a full buffer needs a retire in the same cycle
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_en && full) |-> rm_en);

  // R8: no retire from an empty buffer
  a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    rm_en |-> !empty);

  // R8: full and empty never together
  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  // R4: absent sources never hit
  a_r4_absent_src: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_a_vld |-> !hit_a) and (!src_b_vld |-> !hit_b));

  // R1: nothing held, nothing matched
  a_r1_empty_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (!hit_a && !hit_b));

  // R3: an issue without a retire leaves the buffer non-empty
  a_r3_issue_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_en && !rm_en && !full) |=> !empty);

  // R7: issue and retire together on a full buffer keep it full
  a_r7_full_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (full && ins_en && rm_en) |=> full);
endmodule

bind reg_hazard_board hzb_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ins_en(ins_en), .rm_en(rm_en),
  .src_a_vld(src_a_vld), .src_b_vld(src_b_vld),
  .hit_a(hit_a), .hit_b(hit_b), .full(full), .empty(empty)
);

// File: tb/tb_reg_hazard_board.sv
module tb_reg_hazard_board;
  localparam int IDX_W = 5;
  localparam int NV    = 19;

  logic clk, rst_n;
  logic ins_en, ins_vld, rm_en, src_a_vld, src_b_vld;
  logic [IDX_W-1:0] ins_idx, src_a_idx, src_b_idx;
  logic hit_a, hit_b, full, empty;

  int n_run, n_fail;

  reg_hazard_board #(.IDX_W(IDX_W), .DEPTH(2)) dut (
    .clk(clk), .rst_n(rst_n), .ins_en(ins_en), .ins_vld(ins_vld), .ins_idx(ins_idx),
    .rm_en(rm_en), .src_a_vld(src_a_vld), .src_a_idx(src_a_idx), .hit_a(hit_a),
    .src_b_vld(src_b_vld), .src_b_idx(src_b_idx), .hit_b(hit_b),
    .full(full), .empty(empty)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {ins_en, ins_vld, ins_idx, rm_en, a_vld, a_idx, b_vld, b_idx, hit_a, hit_b, full, empty}
  function automatic logic [23:0] vec(input bit ie, input bit iv, input int ii, input bit rm,
                                      input bit av, input int ai, input bit bv, input int bi,
                                      input bit ha, input bit hb, input bit f, input bit e);
    return {ie, iv, 5'(ii), rm, av, 5'(ai), bv, 5'(bi), ha, hb, f, e};
  endfunction

  localparam logic [23:0] TBL [NV] = '{
    vec(0,0,0, 0, 1,3, 0,0, 0,0, 0,1),  // 0  R1 idle after reset
    vec(1,1,3, 0, 1,3, 0,0, 0,0, 0,1),  // 1  R3 same-cycle issue invisible
    vec(1,1,7, 0, 1,3, 1,7, 1,0, 0,0),  // 2  R2 hit on 3, R3 7 not yet
    vec(0,0,0, 0, 1,3, 1,7, 1,1, 1,0),  // 3  R7 full, R9 both ports
    vec(1,1,9, 1, 1,3, 1,7, 0,1, 1,0),  // 4  R6 retiring 3 hidden, R7 swap
    vec(0,0,0, 0, 1,9, 1,3, 1,0, 1,0),  // 5  R7 new entry visible, R5 3 gone
    vec(0,0,0, 1, 1,7, 1,9, 0,1, 1,0),  // 6  R6 retiring 7 hidden
    vec(0,0,0, 1, 1,9, 0,9, 0,0, 0,0),  // 7  R6 last entry retiring
    vec(1,0,4, 0, 0,9, 0,4, 0,0, 0,1),  // 8  R4 absent dest issued
    vec(1,1,5, 0, 1,4, 0,0, 0,0, 0,0),  // 9  R4 absent dest never matches
    vec(0,0,0, 0, 1,5, 0,5, 1,0, 1,0),  // 10 R4 absent dest takes slot, absent src
    vec(0,0,0, 1, 1,5, 1,4, 1,0, 1,0),  // 11 R5 oldest (absent) retires
    vec(0,0,0, 1, 1,5, 1,0, 0,0, 0,0),  // 12 R5 then 5 retires
    vec(0,0,0, 0, 1,5, 1,0, 0,0, 0,1),  // 13 R8 empty again
    vec(1,1,2, 0, 1,2, 1,2, 0,0, 0,1),  // 14 R10 first copy
    vec(1,1,2, 0, 1,2, 1,3, 1,0, 0,0),  // 15 R10 second copy
    vec(0,0,0, 1, 1,2, 1,2, 1,1, 1,0),  // 16 R10 one copy left
    vec(0,0,0, 1, 1,2, 0,2, 0,0, 0,0),  // 17 R10 last copy retiring
    vec(0,0,0, 0, 1,2, 1,2, 0,0, 0,1)   // 18 R8 empty
  };
  localparam int TAG [NV] = '{1,3,2,7,6,7,6,6,4,4,4,5,5,8,10,10,10,10,8};

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    ins_en = 0; ins_vld = 0; ins_idx = '0; rm_en = 0;
    src_a_vld = 0; src_a_idx = '0; src_b_vld = 0; src_b_idx = '0;
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    n_run = 0; n_fail = 0;
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    src_a_vld = 1; src_a_idx = 5'd3;
    #1;
    chk("R1", "empty in reset", empty, 1'b1);
    chk("R1", "full in reset", full, 1'b0);
    chk("R1", "hit_a in reset", hit_a, 1'b0);
    rst_n = 1;

    for (int k = 0; k < NV; k++) begin
      string r;
      logic [23:0] v;
      @(negedge clk);
      v = TBL[k];
      r = $sformatf("R%0d", TAG[k]);
      {ins_en, ins_vld, ins_idx, rm_en, src_a_vld, src_a_idx, src_b_vld, src_b_idx} = v[23:4];
      #1;
      chk(r, $sformatf("v%0d hit_a", k), hit_a, v[3]);
      chk(r, $sformatf("v%0d hit_b", k), hit_b, v[2]);
      chk(r, $sformatf("v%0d full", k),  full,  v[1]);
      chk(r, $sformatf("v%0d empty", k), empty, v[0]);
    end

    // R1: reset in the middle of operation clears the entries
    @(negedge clk);
    idle_inputs(); ins_en = 1; ins_vld = 1; ins_idx = 5'd0;
    @(negedge clk);
    idle_inputs(); src_a_vld = 1; src_a_idx = 5'd0;
    #1;
    chk("R2", "index 0 pending", hit_a, 1'b1);
    rst_n = 0;
    #1;
    chk("R1", "hit after mid reset", hit_a, 1'b0);
    chk("R1", "empty after mid reset", empty, 1'b1);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1;
    chk("R1", "hit after release", hit_a, 1'b0);
    chk("R1", "full after release", full, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule